// File: doc/BRIEF.md
# Four-word control-gated register file

A small storage array of four words, each four bits wide, addressed by a two-bit index. Three active-high control inputs decide what the unit does in each cycle: a chip select that enables the whole unit, a direction input that picks reading (high) or writing (low), and an output enable that lets read data reach the output.

A write does not happen on every clock while the write condition holds. The block registers the write condition (chip select high and direction low) on the system clock. A write takes place only in the cycle where that condition first becomes true. In that cycle, the word picked by the address decoder captures the write data at the clock edge. Read data is combinational. Each word is masked by its decoder line, and the masked words are OR-combined. When no read is enabled, the result is forced to zero and a valid flag stays low.

Top module: `nibble_store`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, every word is cleared to zero. A read after reset returns 0 from every address.
- R2: With `sel` low, no word changes, whatever the values of `rd_mode` and `out_en`. `rdata` is 0 and `rvalid` is 0.
- R3: With `sel`=1 and `rd_mode`=0, the cycle is a write whatever `out_en` is. The word at `addr` takes `wdata` at the clock edge where this condition is first seen.
- R4: While the write condition stays true over consecutive cycles, no further write occurs. Changes to `addr` or `wdata` during the hold are ignored.
- R5: With `sel`=1, `rd_mode`=1 and `out_en`=0, the unit is idle: `rdata` is 0, `rvalid` is 0 and no word changes.
- R6: With `sel`, `rd_mode` and `out_en` all 1, `rvalid` is 1 and `rdata` equals the word at `addr` in the same cycle.
- R7: A write changes only the addressed word. The other three words keep their values.
- R8: After the write condition is dropped for at least one cycle, raising it again performs a new write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Word index, decoded to one-hot |
| wdata | input | 4 | Data to store |
| sel | input | 1 | Unit enable (chip select) |
| rd_mode | input | 1 | 1 = read direction, 0 = write direction |
| out_en | input | 1 | Lets read data out when reading |
| rdata | output | 4 | OR-combined masked word outputs; 0 when not reading |
| rvalid | output | 1 | High when a read is enabled |

## Verification
A corrupted word stays hidden until that word is read, so the bench reads back every address after each write burst. A stale or missing edge register shows up as an extra or lost write on the very next read of the affected word. A wrong decoder line shows up as damage to a neighbouring word, or as a wrong value in the same cycle that word is read. Because the output path is combinational, a gating fault appears in the same cycle as the control inputs that expose it.

// File: rtl/nibble_store.sv
module nibble_store #(
  parameter int WORDS = 4,
  parameter int WIDTH = 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             sel,
  input  logic             rd_mode,
  input  logic             out_en,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);

  logic [WORDS-1:0][WIDTH-1:0] mem;
  logic [WORDS-1:0][WIDTH-1:0] masked;
  logic [WORDS-1:0]            line;
  logic                        wr_cond, wr_q, wr_strobe, rd_cond;

  assign wr_cond   = sel & ~rd_mode;
  assign rd_cond   = sel & rd_mode & out_en;
  assign wr_strobe = wr_cond & ~wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_cond;
  end

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_word
      assign line[g] = (addr == AW'(g));
      always_ff @(posedge clk) begin
        if (!rst_n)                  mem[g] <= '0;
        else if (wr_strobe && line[g]) mem[g] <= wdata;
      end
      assign masked[g] = mem[g] & {WIDTH{line[g] & rd_cond}};
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < WORDS; i++) rdata = rdata | masked[i];
  end

  assign rvalid = rd_cond;

  // R2
  no_write_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(mem));

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !rd_mode && !wr_q) |=> mem[$past(addr)] == $past(wdata));

  // R4
  no_rewrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !rd_mode && wr_q) |=> $stable(mem));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));

  // R6
  read_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd_mode && out_en) |-> (rvalid && rdata == mem[addr]));

endmodule

// File: tb/nibble_store_bench.sv
module nibble_store_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [3:0] wdata = '0;
  logic       sel = 1'b0, rd_mode = 1'b0, out_en = 1'b0;
  logic [3:0] rdata;
  logic       rvalid;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit done = 1'b0;

  logic [3:0] model [4];
  bit prev_wr = 1'b0;

  always #5 clk = ~clk;

  nibble_store u_nibble_store (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .sel(sel),
    .rd_mode(rd_mode), .out_en(out_en), .rdata(rdata), .rvalid(rvalid)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) model[i] = 4'h0;
      prev_wr = 1'b0;
    end else begin
      if (sel && !rd_mode && !prev_wr) model[addr] = wdata;
      prev_wr = sel && !rd_mode;
    end
  end

  always @(negedge clk) begin
    logic       ev;
    logic [3:0] ed;
    if (!done) begin
      ev = sel && rd_mode && out_en;
      ed = ev ? model[addr] : 4'h0;
      compared++;
      if (rvalid !== ev || rdata !== ed) begin
        mismatched++;
        $display("FAIL %s: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                 tag, rvalid, rdata, ev, ed);
      end
    end
  end

  task automatic step(input bit s, input bit r, input bit o,
                      input logic [1:0] a, input logic [3:0] d);
    @(posedge clk);
    #1;
    sel = s; rd_mode = r; out_en = o; addr = a; wdata = d;
  endtask

  task automatic read_all(input string t);
    tag = t;
    for (int i = 0; i < 4; i++) step(1, 1, 1, 2'(i), 4'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    step(1, 1, 1, 2'd1, 4'h0);
    step(1, 0, 0, 2'd2, 4'hF);
    step(0, 0, 0, 2'd0, 4'h0);
    step(0, 0, 0, 2'd0, 4'h0);
    rst_n = 1'b1;
    read_all("R1");
    tag = "R3";
    step(1, 0, 1, 2'd2, 4'hA);
    tag = "R4";
    step(1, 0, 1, 2'd3, 4'h5);
    step(1, 0, 0, 2'd0, 4'h7);
    step(1, 0, 1, 2'd2, 4'h1);
    tag = "R2";
    step(0, 1, 1, 2'd2, 4'h3);
    step(0, 0, 1, 2'd1, 4'h9);
    step(0, 0, 0, 2'd0, 4'hC);
    step(0, 1, 0, 2'd3, 4'hE);
    read_all("R7");
    tag = "R5";
    step(1, 1, 0, 2'd2, 4'h0);
    step(1, 1, 0, 2'd0, 4'h6);
    tag = "R8";
    for (int i = 0; i < 4; i++) begin
      step(1, 0, i[0], 2'(i), 4'(4'h3 + 4'(i * 3)));
      step(0, 0, 0, 2'(i), 4'h0);
    end
    read_all("R6");
    tag = "R4";
    step(1, 0, 0, 2'd1, 4'hB);
    step(1, 0, 1, 2'd0, 4'hD);
    step(1, 1, 1, 2'd0, 4'h0);
    tag = "R8";
    step(1, 0, 0, 2'd3, 4'h2);
    step(1, 1, 1, 2'd3, 4'h0);
    read_all("R7");
    tag = "R1";
    rst_n = 1'b0;
    step(1, 1, 1, 2'd1, 4'h0);
    step(1, 1, 1, 2'd1, 4'h0);
    rst_n = 1'b1;
    read_all("R1");
    step(0, 0, 0, 2'd0, 4'h0);
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule